// File: doc/BRIEF.md
# Unlock-Guarded Sector-Programming Flash Controller

This block models the control logic of a byte-wide parallel flash array. The chip-enable, output-enable and write-enable strobes (all active low) are sampled on a fast system clock. A read cycle returns the byte stored at the presented address and asserts a data-output-enable flag. Whenever the part is not being read, the flag is low, and this stands in for a high-impedance data bus. The array starts in the erased state, with every byte 0xFF. Its depth is a parameter. With the full 16-bit depth it holds 512 sectors of 128 bytes. Address decoding for the unlock sequence always uses all 16 address bits.

Programming is guarded. Each program operation must start with a fixed three-write key. After the key, byte loads fill a 128-byte sector buffer that starts erased, and the target sector is set by the first load. The operation ends when no accepted load arrives within a byte-load timeout. The buffer is then committed over the whole sector after a modelled write time, which replaces every byte of that sector. A write that is not part of a valid key runs the same write timer but stores nothing. While either timer runs, reads return a polling status word instead of array data. A reset never opens the guard and never alters stored bytes.

Top module: `pflash_front`

## Requirements
- R1: When ce_n=0, oe_n=0 and we_n=1, dout_en is 1. When no write timer is running, dout equals the byte stored at the presented address (addr bits below the array depth). Bytes that have never been programmed read as 0xFF.
- R2: dout_en is 0 whenever ce_n=1 or oe_n=1, including during a write cycle.
- R3: A program operation opens only after three writes in order: 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Each operation needs a fresh key. A byte written after a finished operation without a new key changes nothing.
- R4: A write that breaks the key at any step returns the key detector to its start and changes no stored data.
- R5: A write made with no key open stores nothing. It starts a busy window of COMMIT_CYCLES clocks in which reads return the polling word. Writes made during the busy window are ignored.
- R6: A commit replaces all 128 bytes of the target sector. Offsets that were not loaded in the operation become 0xFF.
- R7: The target sector is addr[ARRAY_AW-1:7] of the first byte load after the key. Loads whose address falls in another sector are ignored.
- R8: Take the last accepted load of an operation at clock edge E. The commit window opens at edge E+LOAD_TIMEOUT and lasts COMMIT_CYCLES clocks. During it a read returns {~L[7], T, 6'b000000}, where L is the last loaded byte and T starts at 0 and inverts after each completed read. Once the window closes, reads return the new data.
- R9: A write captures its address when the later of ce_n and we_n falls, which is the moment both are low with oe_n=1. It captures its data when the first of the two rises.
- R10: A reset returns the key detector to its start and never unlocks programming. Stored bytes survive the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous active-high reset of the control state |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 16 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling status word |
| dout_en | output | 1 | High while the data outputs would be driven |

## Verification
The assertions take the strobes and address to be synchronous to clk and free of glitches. They also assume each strobe level is held for at least one clock edge, so every write or read cycle is seen as one contiguous active interval. The bench changes the strobes only on falling clock edges and holds each phase of a cycle for at least one full clock. This includes the skewed-strobe case, in which we_n falls a clock before ce_n and rises a clock before it. Polling checks are timed from the last accepted load, with the bench's timeout and commit parameters chosen so that every poll falls well inside the busy window.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int OFF_W      = 7;
    localparam int SECT_BYTES = 1 << OFF_W;

    localparam logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555;
    localparam logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [DATA_W-1:0] KEY_DATA_0 = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_DATA_1 = 8'h55;
    localparam logic [DATA_W-1:0] KEY_DATA_2 = 8'hA0;

    typedef enum logic [2:0] {
        ST_LOCKED,
        ST_KEY1,
        ST_KEY2,
        ST_LOAD,
        ST_COMMIT,
        ST_DUMMY
    } fl_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_beat_t;

    // Does a write beat match key step 0, 1 or 2?
    function automatic logic key_match(input wr_beat_t b, input logic [1:0] step);
        case (step)
            2'd0:    return (b.addr == KEY_ADDR_A) && (b.data == KEY_DATA_0);
            2'd1:    return (b.addr == KEY_ADDR_B) && (b.data == KEY_DATA_1);
            2'd2:    return (b.addr == KEY_ADDR_A) && (b.data == KEY_DATA_2);
            default: return 1'b0;
        endcase
    endfunction

    // Status word shown to reads while a write timer runs
    function automatic logic [DATA_W-1:0] poll_word(input logic [DATA_W-1:0] last,
                                                   input logic tog);
        return {~last[DATA_W-1], tog, {(DATA_W-2){1'b0}}};
    endfunction

endpackage

// File: rtl/pf_strobe.sv
module pf_strobe
    import pflash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              rd_act,
    output logic              rd_done,
    output logic              wr_evt,
    output wr_beat_t          wr_beat
);

    logic              wr_act;
    logic              wr_q;
    logic              rd_q;
    logic [ADDR_W-1:0] addr_lat;

    assign wr_act = ~ce_n & ~we_n & oe_n;
    assign rd_act = ~ce_n & ~oe_n & we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            addr_lat <= '0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            // later falling strobe opens the write: capture address
            if (wr_act && !wr_q)
                addr_lat <= addr;
        end
    end

    // first rising strobe closes the write: data taken now
    assign wr_evt       = wr_q & ~wr_act;
    assign wr_beat.addr = addr_lat;
    assign wr_beat.data = din;
    assign rd_done      = rd_q & ~rd_act;

endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
    import pflash_pkg::*;
#(
    parameter int SEC_W         = 3,
    parameter int LOAD_TIMEOUT  = 64,
    parameter int COMMIT_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_evt,
    input  wr_beat_t          wr_beat,
    input  logic              rd_done,
    output logic              busy,
    output logic              commit_pulse,
    output logic              buf_clear,
    output logic              ld_en,
    output logic [OFF_W-1:0]  ld_off,
    output logic [DATA_W-1:0] ld_data,
    output logic [SEC_W-1:0]  sector,
    output logic [DATA_W-1:0] status
);

    localparam int MAXC  = (LOAD_TIMEOUT > COMMIT_CYCLES) ? LOAD_TIMEOUT : COMMIT_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(LOAD_TIMEOUT - 1);
    localparam logic [CNT_W-1:0] WC_LAST  = CNT_W'(COMMIT_CYCLES - 1);

    fl_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic              have_sec;
    logic [SEC_W-1:0]  sec_q;
    logic [DATA_W-1:0] last_q;
    logic              tog;
    logic [1:0]        step;
    logic              key_ok;
    logic [SEC_W-1:0]  beat_sec;

    always_comb begin
        case (st)
            ST_KEY1: step = 2'd1;
            ST_KEY2: step = 2'd2;
            default: step = 2'd0;
        endcase
    end

    assign key_ok       = key_match(wr_beat, step);
    assign beat_sec     = wr_beat.addr[OFF_W +: SEC_W];
    assign ld_en        = (st == ST_LOAD) && wr_evt && (!have_sec || beat_sec == sec_q);
    assign ld_off       = wr_beat.addr[OFF_W-1:0];
    assign ld_data      = wr_beat.data;
    assign buf_clear    = (st == ST_KEY2) && wr_evt && key_ok;
    assign busy         = (st == ST_COMMIT) || (st == ST_DUMMY);
    assign commit_pulse = (st == ST_COMMIT) && (cnt == WC_LAST);
    assign sector       = sec_q;
    assign status       = poll_word(last_q, tog);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_LOCKED;
            cnt      <= '0;
            have_sec <= 1'b0;
            sec_q    <= '0;
            last_q   <= '0;
            tog      <= 1'b0;
        end else begin
            case (st)
                ST_LOCKED, ST_KEY1, ST_KEY2: begin
                    if (wr_evt) begin
                        cnt <= '0;
                        if (key_ok) begin
                            if (st == ST_LOCKED)    st <= ST_KEY1;
                            else if (st == ST_KEY1) st <= ST_KEY2;
                            else begin
                                st       <= ST_LOAD;
                                have_sec <= 1'b0;
                            end
                        end else begin
                            st     <= ST_DUMMY;
                            last_q <= wr_beat.data;
                            tog    <= 1'b0;
                        end
                    end
                end
                ST_LOAD: begin
                    if (ld_en) begin
                        cnt      <= '0;
                        have_sec <= 1'b1;
                        sec_q    <= beat_sec;
                        last_q   <= wr_beat.data;
                    end else if (cnt == TMO_LAST) begin
                        cnt <= '0;
                        tog <= 1'b0;
                        st  <= have_sec ? ST_COMMIT : ST_LOCKED;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (rd_done)
                        tog <= ~tog;
                    if (cnt == WC_LAST) begin
                        cnt <= '0;
                        st  <= ST_LOCKED;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pf_secbuf.sv
module pf_secbuf
    import pflash_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 buf_clear,
    input  logic                                 ld_en,
    input  logic [OFF_W-1:0]                     ld_off,
    input  logic [DATA_W-1:0]                    ld_data,
    output logic [SECT_BYTES-1:0][DATA_W-1:0]    bytes
);

    always_ff @(posedge clk) begin
        if (rst || buf_clear)
            bytes <= '1;
        else if (ld_en)
            bytes[ld_off] <= ld_data;
    end

endmodule

// File: rtl/pf_array.sv
module pf_array
    import pflash_pkg::*;
#(
    parameter int ARRAY_AW = 10
) (
    input  logic                              clk,
    input  logic                              commit,
    input  logic [ARRAY_AW-OFF_W-1:0]         sector,
    input  logic [SECT_BYTES-1:0][DATA_W-1:0] wdata,
    input  logic [ARRAY_AW-1:0]               raddr,
    output logic [DATA_W-1:0]                 rdata
);

    localparam int DEPTH = 1 << ARRAY_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // array powers up erased
    initial begin
        for (int i = 0; i < DEPTH; i++)
            mem[i] = '1;
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < SECT_BYTES; i++)
                mem[{sector, OFF_W'(i)}] <= wdata[i];
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pflash_front.sv
module pflash_front
    import pflash_pkg::*;
#(
    parameter int ARRAY_AW      = 10,
    parameter int LOAD_TIMEOUT  = 64,
    parameter int COMMIT_CYCLES = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [15:0] addr,
    input  logic [7:0]  din,
    output logic [7:0]  dout,
    output logic        dout_en
);

    localparam int SEC_W = ARRAY_AW - OFF_W;

    logic                              rd_act;
    logic                              rd_done;
    logic                              wr_evt;
    wr_beat_t                          wr_beat;
    logic                              busy;
    logic                              commit_pulse;
    logic                              buf_clear;
    logic                              ld_en;
    logic [OFF_W-1:0]                  ld_off;
    logic [DATA_W-1:0]                 ld_data;
    logic [SEC_W-1:0]                  sector;
    logic [DATA_W-1:0]                 status;
    logic [SECT_BYTES-1:0][DATA_W-1:0] sect_bytes;
    logic [DATA_W-1:0]                 arr_rd;

    pf_strobe u_strobe (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .rd_act  (rd_act),
        .rd_done (rd_done),
        .wr_evt  (wr_evt),
        .wr_beat (wr_beat)
    );

    pf_ctrl #(
        .SEC_W         (SEC_W),
        .LOAD_TIMEOUT  (LOAD_TIMEOUT),
        .COMMIT_CYCLES (COMMIT_CYCLES)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_evt       (wr_evt),
        .wr_beat      (wr_beat),
        .rd_done      (rd_done),
        .busy         (busy),
        .commit_pulse (commit_pulse),
        .buf_clear    (buf_clear),
        .ld_en        (ld_en),
        .ld_off       (ld_off),
        .ld_data      (ld_data),
        .sector       (sector),
        .status       (status)
    );

    pf_secbuf u_buf (
        .clk       (clk),
        .rst       (rst),
        .buf_clear (buf_clear),
        .ld_en     (ld_en),
        .ld_off    (ld_off),
        .ld_data   (ld_data),
        .bytes     (sect_bytes)
    );

    pf_array #(.ARRAY_AW(ARRAY_AW)) u_array (
        .clk    (clk),
        .commit (commit_pulse),
        .sector (sector),
        .wdata  (sect_bytes),
        .raddr  (addr[ARRAY_AW-1:0]),
        .rdata  (arr_rd)
    );

    assign dout_en = rd_act;
    assign dout    = busy ? status : arr_rd;

endmodule

// File: rtl/pflash_front_chk.sv
module pflash_front_chk #(
    parameter int COMMIT_CYCLES = 256
) (
    input logic clk,
    input logic rst,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic dout_en,
    input logic busy,
    input logic wr_evt,
    input logic commit_pulse
);

    localparam int BW = $clog2(COMMIT_CYCLES + 1) + 1;

    logic [BW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_run <= '0;
        else              busy_run <= busy_run + 1'b1;
    end

    // R1: a read cycle drives the outputs
    p_read_drive_r1: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && we_n) |-> dout_en);

    // R2: outputs released when either enable is high
    p_hiz_r2: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> !dout_en);

    // R8: a busy window never exceeds the write time
    p_busy_len_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < BW'(COMMIT_CYCLES)));

    // R5: a write landing inside a busy window does not end it early
    p_wr_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_evt && !commit_pulse && busy_run < BW'(COMMIT_CYCLES - 1)) |=> busy);

    // R6: the sector copy happens only inside a busy window
    p_commit_busy_r6: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |-> busy);

    // R8: the copy closes the window
    p_commit_ends_r8: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |=> !busy);

endmodule

bind pflash_front pflash_front_chk #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .dout_en      (dout_en),
    .busy         (busy),
    .wr_evt       (wr_evt),
    .commit_pulse (commit_pulse)
);

// File: tb/test_pflash_front.sv
module test_pflash_front;

    localparam int CLK_P   = 10;
    localparam int AW      = 10;
    localparam int TMO     = 40;
    localparam int WC      = 60;
    localparam int DEPTH   = 1 << AW;
    localparam int NSEC    = DEPTH / 128;
    localparam int WD_CYC  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int vec_cnt = 0;
    int bad_cnt = 0;
    logic [7:0] model [DEPTH];

    always #(CLK_P/2) clk = ~clk;

    pflash_front #(
        .ARRAY_AW      (AW),
        .LOAD_TIMEOUT  (TMO),
        .COMMIT_CYCLES (WC)
    ) i_pflash_front (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    function automatic logic [7:0] pat(input int s, input int o, input int salt);
        return 8'((s * 37 + o * 11 + salt * 5) ^ 8'hC3);
    endfunction

    function automatic logic [15:0] sa(input int s, input int o);
        return 16'((s << 7) | o);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        d = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic en;
        rd(a, d, en);
        check(tag, {7'b0, en}, 8'h01);
        check(tag, d, exp);
    endtask

    task automatic unlock();
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'hA0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < DEPTH; a++)
            rd_chk(tag, 16'(a), model[a]);
    endtask

    task automatic check_sector(input string tag, input int s);
        for (int o = 0; o < 128; o++)
            rd_chk(tag, sa(s, o), model[s * 128 + o]);
    endtask

    initial begin : watchdog
        repeat (WD_CYC) @(posedge clk);
        bad_cnt++;
        $display("FAIL watchdog expired actual=%0d expected=done", WD_CYC);
        $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic en;
        logic [7:0] last;

        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state: outputs released, erased array (R1, R2)
        check("R2 idle dout_en", {7'b0, dout_en}, 8'h00);
        rd_chk("R1 erased read", 16'h0000, 8'hFF);
        rd_chk("R1 erased read top", 16'(DEPTH - 1), 8'hFF);

        // R2: one enable high releases outputs
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        check("R2 ce high", {7'b0, dout_en}, 8'h00);
        ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        check("R2 oe high", {7'b0, dout_en}, 8'h00);
        ce_n = 1'b1;
        @(negedge clk);

        // R5: unguarded write polls then stores nothing
        wr(16'h0012, 8'h3C);
        rd(16'h0012, d, en);
        check("R5 dummy poll", d, {~8'h3C >> 7, 7'b0} & 8'h80);
        rd(16'h0012, d, en);
        check("R5 dummy poll toggle", d, 8'hC0);
        idle(WC + 5);
        rd_chk("R5 no store", 16'h0012, 8'hFF);

        // R3, R8: program every sector fully
        for (int s = 0; s < NSEC; s++) begin
            unlock();
            for (int o = 0; o < 128; o++) begin
                wr(sa(s, o), pat(s, o, 0));
                model[s * 128 + o] = pat(s, o, 0);
            end
            if (s == 0) begin
                last = pat(0, 127, 0);
                idle(TMO + 2);
                rd(16'h0000, d, en);
                check("R8 poll first", d, {~last[7], 1'b0, 6'b0});
                rd(16'h0000, d, en);
                check("R8 poll second", d, {~last[7], 1'b1, 6'b0});
                rd(16'h0000, d, en);
                check("R8 poll third", d, {~last[7], 1'b0, 6'b0});
            end
            idle(TMO + WC + 5);
        end
        sweep("R3 R8 full program");

        // R3: no fresh key, no change
        wr(sa(1, 4), 8'h00);
        idle(WC + 5);
        rd_chk("R3 fresh key needed", sa(1, 4), model[128 + 4]);

        // R6: partial load erases the rest
        unlock();
        for (int o = 0; o < 10; o++) wr(sa(2, o), pat(2, o, 1));
        for (int o = 0; o < 128; o++) model[2 * 128 + o] = (o < 10) ? pat(2, o, 1) : 8'hFF;
        idle(TMO + WC + 5);
        check_sector("R6 auto erase", 2);

        // R7: first load fixes sector
        unlock();
        wr(sa(3, 0), 8'h11);
        wr(sa(4, 0), 8'h22);
        wr(sa(4, 1), 8'h33);
        wr(sa(3, 7), 8'h44);
        for (int o = 0; o < 128; o++) model[3 * 128 + o] = 8'hFF;
        model[3 * 128 + 0] = 8'h11;
        model[3 * 128 + 7] = 8'h44;
        idle(TMO + WC + 5);
        check_sector("R7 target sector", 3);
        check_sector("R7 other sector kept", 4);

        // R4: broken key at third and second step
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'hA1);
        idle(WC + 5);
        wr(sa(5, 3), 8'h5A);
        idle(WC + 5);
        rd_chk("R4 third step mismatch", sa(5, 3), model[5 * 128 + 3]);
        wr(16'h5555, 8'hAA);
        wr(16'h2AAB, 8'h55);
        idle(WC + 5);
        wr(16'h5555, 8'hA0);
        idle(WC + 5);
        wr(sa(5, 9), 8'h5A);
        idle(WC + 5);
        rd_chk("R4 second step mismatch", sa(5, 9), model[5 * 128 + 9]);

        // R9: skewed strobes
        unlock();
        @(negedge clk);
        oe_n = 1'b1; addr = sa(6, 1); din = 8'h00; we_n = 1'b0;
        @(negedge clk);
        addr = sa(6, 5); ce_n = 1'b0;
        @(negedge clk);
        check("R2 during write", {7'b0, dout_en}, 8'h00);
        addr = sa(6, 9);
        @(negedge clk);
        din = 8'h6D; we_n = 1'b1;
        @(negedge clk);
        din = 8'h92; ce_n = 1'b1;
        @(negedge clk);
        for (int o = 0; o < 128; o++) model[6 * 128 + o] = 8'hFF;
        model[6 * 128 + 5] = 8'h6D;
        idle(TMO + WC + 5);
        check_sector("R9 capture points", 6);

        // R10: reset in mid key keeps guard and data
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        wr(16'h5555, 8'hA0);
        idle(WC + 5);
        wr(sa(7, 2), 8'h0F);
        idle(TMO + WC + 5);
        rd_chk("R10 guard after reset", sa(7, 2), model[7 * 128 + 2]);
        sweep("R10 data kept");

        $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

endmodule